// File: doc/BRIEF.md
# Energy-Detect Power Mode Controller

This block chooses the power state of a single network port. A host sets a two-bit mode field and two wake control bits, and supplies a 16-bit timer word that holds two persistence limits. From these and a cable-energy indication, the block drives enable lines for the clock generator, the host interface, the PHY transmit/receive path and the MAC. It also drives a partial receive-gating line used in the power-saving mode and a flag for the low-power substate.

In the energy-detect mode the port sleeps and wakes by itself. A quiet cable that lasts long enough puts it into a low-power substate. A cable that shows energy long enough brings it back, if the host allowed that. Both intervals are counted in ticks of an external time-unit strobe. Each count must be unbroken. When the host allows it, a wake can also rewrite the mode field back to normal operation.

The controller is one state machine with five named states. ST_NORMAL, ST_SOFT_PD and ST_PWR_SAVE follow the mode field directly. ST_ED_AWAKE and ST_ED_ASLEEP are the two substates of energy-detect mode. The transitions are:
- HOST_WRITE: any state goes to the entry state of the written mode.
- GO_SLEEP: ST_ED_AWAKE goes to ST_ED_ASLEEP.
- WAKE_STAY: ST_ED_ASLEEP goes to ST_ED_AWAKE.
- WAKE_NORMAL: ST_ED_ASLEEP goes to ST_NORMAL.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode field reads 00, the four enables (clock, host, PHY, MAC) are 1, and low_pwr and rx_trim are 0.
- R2: The mode field encodes 00 as normal, 01 as energy detect, 10 as soft power down and 11 as power saving. A pulse on mode_wr loads mode_wdata, and the outputs reflect it on the clock after the write. This works from any state.
- R3: In normal mode all four enables are 1, and low_pwr and rx_trim are 0.
- R4: Writing 01 always enters the awake substate with all four enables on and both persistence counts cleared. This holds even when the mode is already 01.
- R5: In the awake substate, the block enters the low-power substate on the tick that completes G+1 consecutive quiet ticks, where G is timer_cfg[7:0]. With G=0 this is the first quiet tick. A quiet tick is a tick with the synchronized energy at 0.
- R6: Synchronized energy at 1 in the awake substate restarts the quiet count from zero.
- R7: In the low-power substate, with auto_wake=1 and wake_to_norm=0, the tick that completes K+1 consecutive energy ticks returns the block to the awake substate. K is timer_cfg[15:8]. The mode stays 01.
- R8: With auto_wake=0 the low-power substate holds however long energy persists, until the host writes the mode.
- R9: With auto_wake=1 and wake_to_norm=1, a wake sets the mode field to 00 and all enables to 1.
- R10: In the low-power substate all four enables are 0 and low_pwr is 1.
- R11: Soft power down drives all four enables to 0, with low_pwr and rx_trim at 0.
- R12: Power saving keeps the clock, host, PHY and MAC enables at 1 and sets rx_trim to 1.
- R13: energy_raw passes through two flip-flops before the counters use it. A tick on the first edge after energy_raw changes still sees the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | One-cycle write strobe for the mode field |
| mode_wdata | input | 2 | New mode field value |
| auto_wake | input | 1 | Allow wake from the low-power substate |
| wake_to_norm | input | 1 | On wake, return to normal mode |
| timer_cfg | input | 2*TIME_W | [15:8] wake limit, [7:0] go-sleep limit |
| energy_raw | input | 1 | Unsynchronized cable-energy indication |
| tick | input | 1 | Time-unit strobe |
| mode_q | output | 2 | Current mode field |
| low_pwr | output | 1 | Low-power substate active |
| rx_trim | output | 1 | Gate unused receive circuitry |
| clk_en | output | 1 | Clock generator enable |
| host_en | output | 1 | Host interface enable |
| phy_en | output | 1 | PHY transmit/receive enable |
| mac_en | output | 1 | MAC enable |

## Verification
The bench uses the default TIME_W=8 and SYNC_STAGES=2, so both limits span 0 to 255 and a level change on energy_raw takes two edges to reach the counters. It sweeps every pair of go-sleep and wake limits from 0 to 4. The sweep alternates the wake-to-normal bit, which puts the exact trigger tick of every short interval, both wake outcomes and the zero-limit case within reach. A run at limit 255 checks the top of the counter range. Separate sequences cover a broken quiet interval, re-entry into mode 01, wake disabled, and a tick that arrives inside the synchronizer latency.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_EDET   = 2'b01,
        MODE_SOFTPD = 2'b10,
        MODE_PSAVE  = 2'b11
    } pm_mode_e;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_ED_AWAKE,
        ST_ED_ASLEEP,
        ST_SOFT_PD,
        ST_PWR_SAVE
    } pm_state_e;

    typedef struct packed {
        logic clk_en;
        logic host_en;
        logic phy_en;
        logic mac_en;
        logic rx_trim;
        logic low_pwr;
    } pm_enables_t;

    function automatic pm_state_e entry_state(input logic [1:0] m);
        pm_state_e s;
        unique case (m)
            MODE_NORMAL: s = ST_NORMAL;
            MODE_EDET:   s = ST_ED_AWAKE;
            MODE_SOFTPD: s = ST_SOFT_PD;
            default:     s = ST_PWR_SAVE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/energy_sync.sv
module energy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/persist_timer.sv
module persist_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             cond_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr_i || !en_i || !cond_i)
            cnt <= '0;
        else if (tick_i && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign hit_o = en_i && !clr_i && cond_i && tick_i && (cnt >= limit_i);

    AST_RUN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !cond_i) |=> (cnt == '0)); // R6

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i && en_i && cond_i) |=> $stable(cnt)); // R5

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int TIME_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_wr,
    input  logic [1:0]            mode_wdata,
    input  logic                  auto_wake,
    input  logic                  wake_to_norm,
    input  logic [2*TIME_W-1:0]   timer_cfg,
    input  logic                  energy_raw,
    input  logic                  tick,
    output logic [1:0]            mode_q,
    output logic                  low_pwr,
    output logic                  rx_trim,
    output logic                  clk_en,
    output logic                  host_en,
    output logic                  phy_en,
    output logic                  mac_en
);
    localparam int TMR_W = 2 * TIME_W;

    pm_state_e   state, state_nx;
    pm_enables_t en;
    logic        energy_s;
    logic        sleep_hit, wake_hit;
    logic [TIME_W-1:0] sleep_lim, wake_lim;

    assign sleep_lim = timer_cfg[TIME_W-1:0];
    assign wake_lim  = timer_cfg[TMR_W-1:TIME_W];

    energy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (energy_raw),
        .q_o   (energy_s)
    );

    persist_timer #(.CNT_W(TIME_W)) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (state == ST_ED_AWAKE),
        .clr_i   (mode_wr),
        .cond_i  (!energy_s),
        .tick_i  (tick),
        .limit_i (sleep_lim),
        .hit_o   (sleep_hit)
    );

    persist_timer #(.CNT_W(TIME_W)) u_active (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (state == ST_ED_ASLEEP),
        .clr_i   (mode_wr),
        .cond_i  (energy_s),
        .tick_i  (tick),
        .limit_i (wake_lim),
        .hit_o   (wake_hit)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (mode_wr) begin
            state_nx = entry_state(mode_wdata);            // HOST_WRITE
        end else begin
            unique case (state)
                ST_ED_AWAKE:
                    if (sleep_hit) state_nx = ST_ED_ASLEEP; // GO_SLEEP
                ST_ED_ASLEEP:
                    if (wake_hit && auto_wake)
                        state_nx = wake_to_norm ? ST_NORMAL    // WAKE_NORMAL
                                                : ST_ED_AWAKE; // WAKE_STAY
                default: state_nx = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        en     = '{clk_en: 1'b1, host_en: 1'b1, phy_en: 1'b1, mac_en: 1'b1,
                   rx_trim: 1'b0, low_pwr: 1'b0};
        mode_q = MODE_NORMAL;
        unique case (state)
            ST_NORMAL:   mode_q = MODE_NORMAL;
            ST_ED_AWAKE: mode_q = MODE_EDET;
            ST_ED_ASLEEP: begin
                mode_q = MODE_EDET;
                en     = '{clk_en: 1'b0, host_en: 1'b0, phy_en: 1'b0, mac_en: 1'b0,
                           rx_trim: 1'b0, low_pwr: 1'b1};
            end
            ST_SOFT_PD: begin
                mode_q = MODE_SOFTPD;
                en     = '{clk_en: 1'b0, host_en: 1'b0, phy_en: 1'b0, mac_en: 1'b0,
                           rx_trim: 1'b0, low_pwr: 1'b0};
            end
            ST_PWR_SAVE: begin
                mode_q     = MODE_PSAVE;
                en.rx_trim = 1'b1;
            end
            default: mode_q = MODE_NORMAL;
        endcase
    end

    assign clk_en  = en.clk_en;
    assign host_en = en.host_en;
    assign phy_en  = en.phy_en;
    assign mac_en  = en.mac_en;
    assign rx_trim = en.rx_trim;
    assign low_pwr = en.low_pwr;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_q == $past(mode_wdata))); // R2

    AST_LOWPWR_IN_ED: assert property (@(posedge clk) disable iff (!rst_n)
        low_pwr |-> (mode_q == MODE_EDET && !clk_en && !mac_en)); // R10

    AST_NO_SLEEP_ON_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ED_AWAKE && !mode_wr && energy_s) |=> (state != ST_ED_ASLEEP)); // R5

    AST_NO_AUTO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ED_ASLEEP && !mode_wr && !auto_wake) |=> (state == ST_ED_ASLEEP)); // R8

    AST_STAY_NOT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ED_ASLEEP && !mode_wr && !wake_to_norm) |=> (mode_q != MODE_NORMAL)); // R7

    AST_SOFTPD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SOFTPD) |-> !(clk_en || host_en || phy_en || mac_en)); // R11

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wdata = 2'b00;
    logic        auto_wake = 1'b0;
    logic        wake_to_norm = 1'b0;
    logic [15:0] timer_cfg = 16'h0000;
    logic        energy_raw = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  mode_q;
    logic        low_pwr, rx_trim, clk_en, host_en, phy_en, mac_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .auto_wake(auto_wake), .wake_to_norm(wake_to_norm), .timer_cfg(timer_cfg),
        .energy_raw(energy_raw), .tick(tick), .mode_q(mode_q), .low_pwr(low_pwr),
        .rx_trim(rx_trim), .clk_en(clk_en), .host_en(host_en), .phy_en(phy_en),
        .mac_en(mac_en)
    );

    // {mode, low_pwr, rx_trim, clk, host, phy, mac}
    function automatic logic [7:0] expect_out(input logic [1:0] m, input logic lp);
        case (m)
            2'b00: return {2'b00, 2'b00, 4'b1111};
            2'b01: return lp ? {2'b01, 2'b10, 4'b0000} : {2'b01, 2'b00, 4'b1111};
            2'b10: return {2'b10, 2'b00, 4'b0000};
            default: return {2'b11, 2'b01, 4'b1111};
        endcase
    endfunction

    task automatic check_out(input string req, input logic [1:0] m, input logic lp);
        logic [7:0] act, exp;
        act = {mode_q, low_pwr, rx_trim, clk_en, host_en, phy_en, mac_en};
        exp = expect_out(m, lp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_mode(input logic [1:0] m);
        mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_energy(input logic e);
        energy_raw = e;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run incomplete, expected end before timeout");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 during reset", 2'b00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset", 2'b00, 1'b0);
        check_out("R3 normal", 2'b00, 1'b0);

        // R2 writes between modes, R11 and R12
        write_mode(2'b10); check_out("R11 soft power down", 2'b10, 1'b0);
        write_mode(2'b11); check_out("R12 power saving", 2'b11, 1'b0);
        write_mode(2'b10); check_out("R2 save->softpd", 2'b10, 1'b0);
        write_mode(2'b00); check_out("R2 softpd->normal", 2'b00, 1'b0);

        // R13 synchronizer latency, limit 0
        timer_cfg = 16'h0000; auto_wake = 1'b0;
        set_energy(1'b1);
        write_mode(2'b01); check_out("R4 entry", 2'b01, 1'b0);
        energy_raw = 1'b0; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check_out("R13 tick sees old energy", 2'b01, 1'b0);
        @(negedge clk);
        pulse(1); check_out("R13 synced quiet sleeps", 2'b01, 1'b1);

        // sweep of both limits: R5 R7 R9 R10
        for (int g = 0; g < 5; g++) begin
            for (int k = 0; k < 5; k++) begin
                logic tonorm;
                tonorm = ((g + k) % 2) == 1;
                timer_cfg = {8'(k), 8'(g)};
                auto_wake = 1'b1; wake_to_norm = tonorm;
                set_energy(1'b0);
                write_mode(2'b01); check_out("R4 sweep entry", 2'b01, 1'b0);
                pulse(g); check_out("R5 before go-sleep limit", 2'b01, 1'b0);
                pulse(1); check_out("R10 asleep", 2'b01, 1'b1);
                set_energy(1'b1);
                pulse(k); check_out("R7 before wake limit", 2'b01, 1'b1);
                pulse(1);
                if (tonorm) check_out("R9 wake to normal", 2'b00, 1'b0);
                else        check_out("R7 wake stays in mode", 2'b01, 1'b0);
            end
        end

        // R6 broken quiet interval
        timer_cfg = 16'h0003; wake_to_norm = 1'b0;
        set_energy(1'b0);
        write_mode(2'b01);
        pulse(2);
        set_energy(1'b1);
        set_energy(1'b0);
        pulse(3); check_out("R6 restart after energy", 2'b01, 1'b0);
        pulse(1); check_out("R6 sleep after full run", 2'b01, 1'b1);

        // R4 re-entry clears count
        write_mode(2'b01); check_out("R4 rewrite wakes", 2'b01, 1'b0);
        pulse(3);
        write_mode(2'b01);
        pulse(3); check_out("R4 count cleared on rewrite", 2'b01, 1'b0);
        pulse(1); check_out("R4 sleep after fresh run", 2'b01, 1'b1);

        // R8 wake disabled
        auto_wake = 1'b0;
        set_energy(1'b1);
        pulse(20); check_out("R8 no auto wake", 2'b01, 1'b1);
        write_mode(2'b00); check_out("R2 host exits low power", 2'b00, 1'b0);

        // R5 top of range, limit 255
        timer_cfg = 16'h00FF;
        set_energy(1'b0);
        write_mode(2'b01);
        pulse(255); check_out("R5 limit 255 not yet", 2'b01, 1'b0);
        pulse(1); check_out("R5 limit 255 sleeps", 2'b01, 1'b1);
        write_mode(2'b00); check_out("R3 back to normal", 2'b00, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule